// File: doc/BRIEF.md
# Accumulator ALU with Flag Update

This block is the arithmetic and logic stage of a small accumulator machine. In each cycle it takes an eight-bit operation code, the accumulator value, the value of register B, an immediate byte from the instruction stream and the machine's current four-bit flag word. At the next rising clock edge it registers the result byte and the next flag word. The surrounding core fetches instructions, selects which register feeds the accumulator input, and writes the result back.

The operations are addition and subtraction with and without carry, single-step increment and decrement, bitwise AND/OR/XOR, an explicit clear of the arithmetic flags, and seven shift and rotate forms. Each operation class updates its own subset of the flags. The interrupt-enable flag is carried through untouched, so the core keeps sole control of it. Any operation code outside the ALU's set passes the accumulator through unchanged and leaves every flag as it was.

For the increment and decrement codes, the core places the register being stepped on the accumulator input. The same unit therefore serves every eight-bit register.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, both outputs are cleared to zero at that edge. The reset is synchronous and active high.
- R2: Results and flags for the inputs present at a rising edge appear on `res_q` and `flags_q` after that edge, and not before. Every operation takes one cycle.
- R3: Codes 0x40/0x41 add, and 0x42/0x43 add with carry (plus one when C is set on entry). Even codes use `reg_b_in` and odd codes use `imm_in`. C is set exactly when the true sum is above 0xFF.
- R4: Codes 0x44/0x45 subtract, and 0x46/0x47 subtract with borrow (minus one more when C is set on entry). Even codes use B and odd codes use the immediate. C is set exactly when the true difference is below zero.
- R5: The flag word uses bit 0 for Z, bit 1 for S, bit 2 for C and bit 3 for I. When an operation updates Z, Z is set exactly when the result byte is zero. When it updates S, S equals bit 7 of the result byte.
- R6: Codes 0x50 to 0x56 increment and 0x60 to 0x66 decrement `acc_in` by one, with wrap-around. They update Z and S and leave C unchanged.
- R7: Codes 0x70/0x71 (AND), 0x72/0x73 (OR) and 0x74/0x75 (XOR) combine the accumulator with B (even code) or the immediate (odd code). They update only Z.
- R8: Code 0x4F clears Z, S and C, leaves I unchanged, and returns the accumulator unchanged.
- R9: Code 0x78 rotates left through C. Code 0x79 rotates left with bit 7 copied into bit 0 and into C. Code 0x7A rotates right through C. Code 0x7B rotates right with bit 0 copied into bit 7 and into C. Code 0x7C shifts left, filling with zero. Code 0x7D shifts right, keeping bit 7. Code 0x7E shifts right, filling with zero. In the three shift forms the bit shifted out goes into C. All seven forms update Z and S.
- R10: No operation changes I. The I bit of `flags_q` equals the I bit of `flags_in` from the previous edge.
- R11: Every code not listed above returns the accumulator unchanged and all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 8 | Operation code |
| acc_in | input | DW | Accumulator, or the register being stepped |
| reg_b_in | input | DW | Register B operand |
| imm_in | input | DW | Immediate operand |
| flags_in | input | 4 | Current flags {I, C, S, Z} |
| res_q | output | DW | Registered result |
| flags_q | output | 4 | Registered next flags {I, C, S, Z} |

## Verification
The bench builds the unit with its default data width of eight bits, which makes the carry and sign positions the ones the operation codes assume. It sweeps all 256 accumulator values for every ALU code, against operand bytes placed at the carry and sign boundaries (0x00, 0x01, 0x80, 0xFF), with the incoming carry both clear and set. In the immediate forms, B holds the complement of the immediate, so a wrong operand selection changes the result. All 256 codes are swept to confirm that codes outside the set change nothing.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPW    = 8;
  localparam int NFLAGS = 4;
  localparam int FLAG_Z = 0;
  localparam int FLAG_S = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_I = 3;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ARITH,
    CLS_STEP,
    CLS_LOGIC,
    CLS_SHIFT,
    CLS_CLRF
  } op_class_e;

  function automatic op_class_e classify(input logic [OPW-1:0] op);
    op_class_e c;
    if (op[7:3] == 5'b01000)
      c = CLS_ARITH;
    else if (op == 8'h4F)
      c = CLS_CLRF;
    else if ((op[7:4] == 4'h5 || op[7:4] == 4'h6) && op[3:0] <= 4'h6)
      c = CLS_STEP;
    else if (op[7:3] == 5'b01110 && op[2:1] != 2'b11)
      c = CLS_LOGIC;
    else if (op[7:3] == 5'b01111 && op[2:0] != 3'b111)
      c = CLS_SHIFT;
    else
      c = CLS_NONE;
    return c;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int EW = DW + 1;

  logic [EW-1:0] wide;
  logic [EW-1:0] extra;

  always_comb begin
    extra = {{DW{1'b0}}, cin};
    if (sub)
      wide = {1'b0, a} - {1'b0, b} - extra;
    else
      wide = {1'b0, a} + {1'b0, b} + extra;
    res  = wide[DW-1:0];
    cout = wide[DW];
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] res
);
  always_comb begin
    case (sel)
      2'b00:   res = a & b;
      2'b01:   res = a | b;
      2'b10:   res = a ^ b;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic [2:0]    sel,
  output logic [DW-1:0] res,
  output logic          cout
);
  always_comb begin
    res  = a;
    cout = cin;
    case (sel)
      3'd0: begin res = {a[DW-2:0], cin};     cout = a[DW-1]; end
      3'd1: begin res = {a[DW-2:0], a[DW-1]}; cout = a[DW-1]; end
      3'd2: begin res = {cin, a[DW-1:1]};     cout = a[0];    end
      3'd3: begin res = {a[0], a[DW-1:1]};    cout = a[0];    end
      3'd4: begin res = {a[DW-2:0], 1'b0};    cout = a[DW-1]; end
      3'd5: begin res = {a[DW-1], a[DW-1:1]}; cout = a[0];    end
      3'd6: begin res = {1'b0, a[DW-1:1]};    cout = a[0];    end
      default: begin res = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPW-1:0]    op_code,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     reg_b_in,
  input  logic [DW-1:0]     imm_in,
  input  logic [NFLAGS-1:0] flags_in,
  output logic [DW-1:0]     res_q,
  output logic [NFLAGS-1:0] flags_q
);

  op_class_e         cls;
  logic [DW-1:0]     operand;
  logic [DW-1:0]     as_b;
  logic              as_cin;
  logic              as_sub;
  logic [DW-1:0]     as_res;
  logic              as_cout;
  logic [DW-1:0]     lg_res;
  logic [DW-1:0]     sh_res;
  logic              sh_cout;
  logic [DW-1:0]     nxt_res;
  logic [NFLAGS-1:0] nxt_flags;
  logic              res_zero;

  // Decode and operand steering
  always_comb begin
    cls     = classify(op_code);
    operand = op_code[0] ? imm_in : reg_b_in;
    if (cls == CLS_STEP) begin
      as_b   = DW'(1);
      as_cin = 1'b0;
      as_sub = (op_code[7:4] == 4'h6);
    end else begin
      as_b   = operand;
      as_cin = op_code[1] & flags_in[FLAG_C];
      as_sub = op_code[2];
    end
  end

  alu_addsub #(.DW(DW)) u_addsub (
    .a    (acc_in),
    .b    (as_b),
    .cin  (as_cin),
    .sub  (as_sub),
    .res  (as_res),
    .cout (as_cout)
  );

  alu_bitwise #(.DW(DW)) u_bitwise (
    .a   (acc_in),
    .b   (operand),
    .sel (op_code[2:1]),
    .res (lg_res)
  );

  alu_shifter #(.DW(DW)) u_shifter (
    .a    (acc_in),
    .cin  (flags_in[FLAG_C]),
    .sel  (op_code[2:0]),
    .res  (sh_res),
    .cout (sh_cout)
  );

  // Result selection and per-class flag update
  always_comb begin
    case (cls)
      CLS_ARITH, CLS_STEP: nxt_res = as_res;
      CLS_LOGIC:           nxt_res = lg_res;
      CLS_SHIFT:           nxt_res = sh_res;
      default:             nxt_res = acc_in;
    endcase
    res_zero  = (nxt_res == '0);
    nxt_flags = flags_in;
    case (cls)
      CLS_ARITH: begin
        nxt_flags[FLAG_Z] = res_zero;
        nxt_flags[FLAG_S] = nxt_res[DW-1];
        nxt_flags[FLAG_C] = as_cout;
      end
      CLS_STEP: begin
        nxt_flags[FLAG_Z] = res_zero;
        nxt_flags[FLAG_S] = nxt_res[DW-1];
      end
      CLS_LOGIC: begin
        nxt_flags[FLAG_Z] = res_zero;
      end
      CLS_SHIFT: begin
        nxt_flags[FLAG_Z] = res_zero;
        nxt_flags[FLAG_S] = nxt_res[DW-1];
        nxt_flags[FLAG_C] = sh_cout;
      end
      CLS_CLRF: begin
        nxt_flags[FLAG_Z] = 1'b0;
        nxt_flags[FLAG_S] = 1'b0;
        nxt_flags[FLAG_C] = 1'b0;
      end
      default: nxt_flags = flags_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      res_q   <= nxt_res;
      flags_q <= nxt_flags;
    end
  end

  // Assertions
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && flags_q == '0));

  p_zs_from_result_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(cls) == CLS_ARITH || $past(cls) == CLS_STEP ||
                     $past(cls) == CLS_SHIFT))
    |-> (flags_q[FLAG_Z] == (res_q == '0) && flags_q[FLAG_S] == res_q[DW-1]));

  p_step_keeps_c_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cls) == CLS_STEP)
    |-> flags_q[FLAG_C] == $past(flags_in[FLAG_C]));

  p_logic_only_z_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cls) == CLS_LOGIC)
    |-> (flags_q[FLAG_C] == $past(flags_in[FLAG_C]) &&
         flags_q[FLAG_S] == $past(flags_in[FLAG_S]) &&
         flags_q[FLAG_Z] == (res_q == '0)));

  p_clear_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cls) == CLS_CLRF)
    |-> (flags_q[FLAG_C] == 1'b0 && flags_q[FLAG_S] == 1'b0 &&
         flags_q[FLAG_Z] == 1'b0 && res_q == $past(acc_in)));

  p_i_untouched_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flags_q[FLAG_I] == $past(flags_in[FLAG_I]));

  p_passthrough_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cls) == CLS_NONE)
    |-> (res_q == $past(acc_in) && flags_q == $past(flags_in)));

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_code = 8'h00;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] reg_b_in = 8'h00;
  logic [7:0] imm_in = 8'h00;
  logic [3:0] flags_in = 4'h0;
  logic [7:0] res_q;
  logic [3:0] flags_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu #(.DW(8)) u0 (
    .clk      (clk),
    .rst      (rst),
    .op_code  (op_code),
    .acc_in   (acc_in),
    .reg_b_in (reg_b_in),
    .imm_in   (imm_in),
    .flags_in (flags_in),
    .res_q    (res_q),
    .flags_q  (flags_q)
  );

  // Reference model written from the requirements; flags {I,C,S,Z}
  function automatic logic [11:0] ref_model(input logic [7:0] op, input logic [7:0] a,
                                            input logic [7:0] b, input logic [7:0] imm,
                                            input logic [3:0] f);
    logic [7:0] r;
    logic [7:0] src;
    logic [3:0] nf;
    int t;
    bit cy;
    r   = a;
    nf  = f;
    cy  = f[2];
    src = op[0] ? imm : b;
    if (op >= 8'h40 && op <= 8'h43) begin
      t = int'(a) + int'(src) + ((op >= 8'h42 && cy) ? 1 : 0);
      r = t[7:0]; nf[2] = (t > 255); nf[0] = (r == 0); nf[1] = r[7];
    end else if (op >= 8'h44 && op <= 8'h47) begin
      t = int'(a) - int'(src) - ((op >= 8'h46 && cy) ? 1 : 0);
      r = t[7:0]; nf[2] = (t < 0); nf[0] = (r == 0); nf[1] = r[7];
    end else if (op == 8'h4F) begin
      nf[2:0] = 3'b000;
    end else if (op >= 8'h50 && op <= 8'h56) begin
      r = a + 8'd1; nf[0] = (r == 0); nf[1] = r[7];
    end else if (op >= 8'h60 && op <= 8'h66) begin
      r = a - 8'd1; nf[0] = (r == 0); nf[1] = r[7];
    end else if (op >= 8'h70 && op <= 8'h75) begin
      if (op <= 8'h71)      r = a & src;
      else if (op <= 8'h73) r = a | src;
      else                  r = a ^ src;
      nf[0] = (r == 0);
    end else if (op >= 8'h78 && op <= 8'h7E) begin
      case (op)
        8'h78: begin r = {a[6:0], cy};   nf[2] = a[7]; end
        8'h79: begin r = {a[6:0], a[7]}; nf[2] = a[7]; end
        8'h7A: begin r = {cy, a[7:1]};   nf[2] = a[0]; end
        8'h7B: begin r = {a[0], a[7:1]}; nf[2] = a[0]; end
        8'h7C: begin r = {a[6:0], 1'b0}; nf[2] = a[7]; end
        8'h7D: begin r = {a[7], a[7:1]}; nf[2] = a[0]; end
        default: begin r = {1'b0, a[7:1]}; nf[2] = a[0]; end
      endcase
      nf[0] = (r == 0); nf[1] = r[7];
    end
    return {nf, r};
  endfunction

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%02h a=%02h: got res=%02h flags=%h, expected res=%02h flags=%h",
               tag, op_code, acc_in, got[7:0], got[11:8], exp[7:0], exp[11:8]);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic apply(input string tag, input logic [7:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] imm, input logic [3:0] f);
    logic [11:0] exp;
    exp = ref_model(op, a, b, imm, f);
    op_code = op; acc_in = a; reg_b_in = b; imm_in = imm; flags_in = f;
    @(negedge clk);
    check(tag, {flags_q, res_q}, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    op_code = 8'h40; acc_in = 8'h12; reg_b_in = 8'h34; flags_in = 4'hF;
    @(negedge clk); @(negedge clk);
    check("R1 reset", {flags_q, res_q}, 12'h000);
    rst = 1'b0;
    op_code = 8'h40; acc_in = 8'h03; reg_b_in = 8'h04; imm_in = 8'h00; flags_in = 4'h8;
    #1;
    check("R2 before edge", {flags_q, res_q}, 12'h000);
    @(posedge clk); #1;
    check("R2 after edge", {flags_q, res_q}, 12'h807);
    @(negedge clk);
  endtask

  task automatic t_arith;
    logic [7:0] bset [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
    for (int op = 8'h40; op <= 8'h47; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 4; k++)
          for (int c = 0; c < 2; c++) begin
            logic [7:0] bv;
            bv = bset[k];
            if (op[0]) apply(op < 8'h44 ? "R3/R5/R10 add imm" : "R4/R5/R10 sub imm",
                             8'(op), 8'(a), ~bv, bv, {a[0], c[0], 2'b00});
            else       apply(op < 8'h44 ? "R3/R5 add B" : "R4/R5 sub B",
                             8'(op), 8'(a), bv, ~bv, {a[0], c[0], 2'b11});
          end
  endtask

  task automatic t_step;
    for (int op = 8'h50; op <= 8'h66; op++) begin
      if (op[3:0] > 4'h6) continue;
      for (int a = 0; a < 256; a++) begin
        apply("R6/R5 step C clear", 8'(op), 8'(a), 8'h55, 8'hAA, 4'b0011);
        apply("R6/R10 step C set", 8'(op), 8'(a), 8'h55, 8'hAA, 4'b1100);
      end
    end
  endtask

  task automatic t_logic;
    logic [7:0] bset [5] = '{8'h00, 8'hFF, 8'h0F, 8'hA5, 8'h80};
    for (int op = 8'h70; op <= 8'h75; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 5; k++) begin
          if (op[0]) apply("R7 logic imm", 8'(op), 8'(a), ~bset[k], bset[k], 4'(k + a));
          else       apply("R7 logic B", 8'(op), 8'(a), bset[k], ~bset[k], 4'(k + a));
        end
  endtask

  task automatic t_clrf;
    for (int f = 0; f < 16; f++)
      apply("R8/R10 clear flags", 8'h4F, 8'(f * 17), 8'h11, 8'h22, 4'(f));
  endtask

  task automatic t_shift;
    for (int op = 8'h78; op <= 8'h7E; op++)
      for (int a = 0; a < 256; a++) begin
        apply("R9/R5 shift C clear", 8'(op), 8'(a), 8'h00, 8'h00, 4'b1000);
        apply("R9/R5 shift C set", 8'(op), 8'(a), 8'h00, 8'h00, 4'b0111);
      end
  endtask

  task automatic t_passthru;
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      if ((o >= 8'h40 && o <= 8'h47) || o == 8'h4F || (o >= 8'h50 && o <= 8'h56) ||
          (o >= 8'h60 && o <= 8'h66) || (o >= 8'h70 && o <= 8'h75) ||
          (o >= 8'h78 && o <= 8'h7E))
        continue;
      apply("R11 pass-through", o, o ^ 8'h5A, 8'h01, 8'hFF, o[3:0]);
      apply("R11 pass-through zero", o, 8'h00, 8'h80, 8'h7F, ~o[3:0]);
    end
  endtask

  initial begin
    t_reset();
    t_arith();
    t_step();
    t_logic();
    t_clrf();
    t_shift();
    t_passthru();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule